// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Serial Code Loader

This block is the digital front end of a two-channel, 12-bit converter. A host writes a code over a three-wire serial port made of a serial clock, a data line and an active-low select. The code goes into one shared shift register. Two separate active-low load strobes then copy that register into either of two holding registers. The two held codes drive the converter inputs.

The load strobes are level-sensitive. While a strobe is low, its holding register follows the shift register. When the strobe returns high, the holding register keeps the last value it took. A clear input forces both holding registers to zero or to half scale; a select pin chooses which. The clear overrides both strobes. When the clear is released, any strobe that is still low takes over again. An active-low shutdown input appears at the output as a power-down flag and has no effect on any register.

All pin inputs pass through two-flop synchronisers on the system clock. A serial clock edge is accepted when the synchronised serial clock is seen to rise. A one-cycle flag reports each serial edge that is accepted while a strobe is low.

Top module: `dual_dac_loader`

## Requirements
- R1: On each accepted rising edge of the serial clock, the shift register moves one place toward its top bit and takes the data line into bit 0, so the first bit sent ends up as the most significant bit.
- R2: Serial clock edges that occur while the select input is high do not change the shift register.
- R3: If more than 12 bits are clocked in during one select period, only the last 12 bits remain. For a 16-bit frame, the first four bits have no effect.
- R4: While a load strobe is low, its holding register follows the shift register. After the strobe goes high, the holding register keeps its value.
- R5: The two strobes are independent. Pulsing one strobe leaves the other channel's code unchanged, and pulsing both strobes loads the same value into both channels.
- R6: While the clear input is low, both codes equal 12'h800 if the half-scale select is high, and 12'h000 if it is low. This holds whatever the load strobes are doing.
- R7: When the clear input is released while a strobe is still low, that channel takes the current shift-register value. A channel whose strobe is high keeps the clear value.
- R8: The power-down output is high exactly when the active-low shutdown input is low. Shutdown does not change either code or the shift register, and serial loading and strobing keep working while it is asserted.
- R9: The violation flag goes high for one cycle for each accepted serial clock edge that occurs while either strobe is low. It stays low otherwise.
- R10: After the system reset, the shift register and both codes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset (power-on reset) |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_sel_n | input | 1 | Active-low serial select; enables the serial clock |
| ser_din | input | 1 | Serial data, most significant bit first |
| load_a_n | input | 1 | Active-low level-sensitive load strobe for channel A |
| load_b_n | input | 1 | Active-low level-sensitive load strobe for channel B |
| clear_n | input | 1 | Active-low clear for both holding registers |
| clear_half | input | 1 | Clear value select: 1 gives half scale, 0 gives zero |
| wake_n | input | 1 | Active-low shutdown request |
| code_a | output | 12 | Held code for channel A |
| code_b | output | 12 | Held code for channel B |
| power_down | output | 1 | Power-down flag for the converter |
| proto_err | output | 1 | One-cycle pulse: serial edge accepted while a strobe was low |

## Verification
Two events can land in the same cycle: a clear being released and a load strobe that is still low. A third case is a clear that is asserted while a strobe is low. Directed sequences hold a strobe low through the whole clear pulse. The bench checks that both codes show the clear value while the clear is low. After release, only the strobed channel should switch to the shift-register contents, and the other channel should keep the clear value. A further sequence shifts bits while a strobe is low, so that accepted serial edges and transparent loading happen together. The bench checks that the code follows each shift and counts the violation pulses.

// File: rtl/dac_ld_pkg.sv
package dac_ld_pkg;
   localparam int NUM_CH   = 2;
   localparam int NUM_SYNC = 8;

   typedef enum int {
      SI_SCLK  = 0,
      SI_SEL   = 1,
      SI_DIN   = 2,
      SI_LDA   = 3,
      SI_LDB   = 4,
      SI_CLR   = 5,
      SI_HALF  = 6,
      SI_WAKE  = 7
   } sync_idx_e;

   // idle levels of the synchronised pins, index as sync_idx_e
   localparam logic [NUM_SYNC-1:0] SYNC_IDLE = 8'b1011_1010;
endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
   parameter int              WIDTH   = 8,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] IDLE   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sync_bus needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= IDLE;
            end else if (s == 0) begin
               stage_q[s] <= d;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sel_n_s,
   input  logic              din_s,
   output logic [DATA_W-1:0] shift_q,
   output logic              edge_ok
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_shifter needs DATA_W of at least 2");
      end
   endgenerate

   logic sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign edge_ok = sclk_s & ~sclk_prev & ~sel_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
      end else if (edge_ok) begin
         shift_q <= {shift_q[DATA_W-2:0], din_s};
      end
   end

   assert_sel_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_s |=> $stable(shift_q));

   assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
      edge_ok |=> (shift_q[0] == $past(din_s)) &&
                  (shift_q[DATA_W-1:1] == $past(shift_q[DATA_W-2:0])));
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n_s,
   input  logic              half_s,
   input  logic              load_n_s,
   input  logic [DATA_W-1:0] shift_q,
   output logic [DATA_W-1:0] code_q
);
   localparam logic [DATA_W-1:0] HALF_CODE = {1'b1, {(DATA_W-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (!clr_n_s) begin
         code_q <= half_s ? HALF_CODE : '0;
      end else if (!load_n_s) begin
         code_q <= shift_q;
      end
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n_s && clr_n_s) |=> $stable(code_q));

   assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n_s && clr_n_s) |=> code_q == $past(shift_q));

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n_s && !half_s) |=> code_q == '0);
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
   import dac_ld_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_sel_n,
   input  logic              ser_din,
   input  logic              load_a_n,
   input  logic              load_b_n,
   input  logic              clear_n,
   input  logic              clear_half,
   input  logic              wake_n,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b,
   output logic              power_down,
   output logic              proto_err
);
   logic [NUM_SYNC-1:0] raw_in;
   logic [NUM_SYNC-1:0] syn;
   logic [DATA_W-1:0]   shift_q;
   logic                edge_ok;
   logic [NUM_CH-1:0]   load_n_s;
   logic [DATA_W-1:0]   codes [NUM_CH];

   always_comb begin
      raw_in          = '0;
      raw_in[SI_SCLK] = ser_clk;
      raw_in[SI_SEL]  = ser_sel_n;
      raw_in[SI_DIN]  = ser_din;
      raw_in[SI_LDA]  = load_a_n;
      raw_in[SI_LDB]  = load_b_n;
      raw_in[SI_CLR]  = clear_n;
      raw_in[SI_HALF] = clear_half;
      raw_in[SI_WAKE] = wake_n;
   end

   sync_bus #(.WIDTH(NUM_SYNC), .STAGES(SYNC_STAGES), .IDLE(SYNC_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

   serial_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(syn[SI_SCLK]), .sel_n_s(syn[SI_SEL]), .din_s(syn[SI_DIN]),
      .shift_q(shift_q), .edge_ok(edge_ok));

   assign load_n_s = {syn[SI_LDB], syn[SI_LDA]};

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         hold_reg #(.DATA_W(DATA_W)) u_hold (
            .clk(clk), .rst_n(rst_n),
            .clr_n_s(syn[SI_CLR]), .half_s(syn[SI_HALF]),
            .load_n_s(load_n_s[c]), .shift_q(shift_q),
            .code_q(codes[c]));
      end
   endgenerate

   assign code_a     = codes[0];
   assign code_b     = codes[1];
   assign power_down = ~syn[SI_WAKE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) proto_err <= 1'b0;
      else        proto_err <= edge_ok & ~(&load_n_s);
   end

   assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> !proto_err);

   assert_pd_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(power_down) && syn[SI_CLR] && (&load_n_s)) |->
         ($stable(code_a) && $stable(code_b)));

   assert_no_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((&load_n_s) && $past(&load_n_s)) |=> !proto_err);
endmodule

// File: tb/tb_dual_dac_loader.sv
module tb_dual_dac_loader;
   localparam int W = 12;
   localparam int SETTLE = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
   logic load_a_n = 1'b1, load_b_n = 1'b1;
   logic clear_n = 1'b1, clear_half = 1'b0, wake_n = 1'b1;
   logic [W-1:0] code_a, code_b;
   logic power_down, proto_err;

   int checks = 0, errors = 0, err_pulses = 0;
   logic [W-1:0] m_sh = '0, m_a = '0, m_b = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dual_dac_loader dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
      .ser_din(ser_din), .load_a_n(load_a_n), .load_b_n(load_b_n),
      .clear_n(clear_n), .clear_half(clear_half), .wake_n(wake_n),
      .code_a(code_a), .code_b(code_b), .power_down(power_down),
      .proto_err(proto_err));

   always @(negedge clk) if (rst_n && proto_err) err_pulses++;

   function automatic logic [W-1:0] clr_val(input logic half);
      return half ? 12'h800 : 12'h000;
   endfunction

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_codes(input string req);
      check({req, " code_a"}, code_a, m_a);
      check({req, " code_b"}, code_b, m_b);
   endtask

   task automatic send_bit(input logic b, input logic counted);
      ser_clk = 1'b0; ser_din = b;
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(3);
      if (counted) m_sh = {m_sh[W-2:0], b};
      ser_clk = 1'b0;
   endtask

   task automatic send_frame(input logic [15:0] bits, input int len);
      ser_sel_n = 1'b0; wait_clk(3);
      for (int i = len-1; i >= 0; i--) send_bit(bits[i], 1'b1);
      wait_clk(3); ser_sel_n = 1'b1; wait_clk(3);
   endtask

   task automatic strobe(input logic a, input logic b);
      load_a_n = ~a; load_b_n = ~b;
      wait_clk(SETTLE);
      if (a) m_a = m_sh;
      if (b) m_b = m_sh;
      load_a_n = 1'b1; load_b_n = 1'b1;
      wait_clk(SETTLE);
   endtask

   task automatic pulse_clear(input logic half);
      clear_half = half; clear_n = 1'b0;
      wait_clk(SETTLE);
      m_a = clr_val(half); m_b = clr_val(half);
      check_codes("R6 clear");
      clear_n = 1'b1; wait_clk(SETTLE);
   endtask

   initial begin
      #(190000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int pulses0;
      void'($urandom(32'h1234_abcd));
      wait_clk(4); rst_n = 1'b1; wait_clk(SETTLE);

      // R10 power-on state
      check_codes("R10 reset");
      check("R8 pd idle", power_down, 0);
      strobe(1'b1, 1'b1);
      check_codes("R10 shift zero");

      // R1 MSB first, R5 independent A only
      send_frame(16'h0A5C, 12);
      strobe(1'b1, 1'b0);
      check("R1 msb first", code_a, 12'hA5C);
      check_codes("R5 A only");

      // R2 clocks while deselected are ignored
      for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
      strobe(1'b0, 1'b1);
      check("R2 sel high ignored", code_b, 12'hA5C);
      check_codes("R2");

      // R3 16-bit frame, top four ignored
      send_frame(16'hF123, 16);
      strobe(1'b1, 1'b1);
      check("R3 last 12 kept", code_a, 12'h123);
      check_codes("R3 both R5");

      // R6 clear overrides strobe held low; R7 release hands over
      send_frame(16'h0777, 12);
      load_a_n = 1'b0; wait_clk(SETTLE);
      m_a = m_sh;
      check_codes("R4 transparent");
      clear_half = 1'b1; clear_n = 1'b0; wait_clk(SETTLE);
      m_a = 12'h800; m_b = 12'h800;
      check_codes("R6 override strobe");
      clear_n = 1'b1; wait_clk(SETTLE);
      m_a = m_sh;
      check_codes("R7 release with strobe low");
      load_a_n = 1'b1; wait_clk(SETTLE);
      check_codes("R4 hold after strobe");
      pulse_clear(1'b0);

      // R9 shifting while strobe low: follows and flags
      pulses0 = err_pulses;
      load_b_n = 1'b0; wait_clk(SETTLE);
      ser_sel_n = 1'b0; wait_clk(3);
      send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
      wait_clk(3); ser_sel_n = 1'b1;
      wait_clk(SETTLE);
      m_b = m_sh;
      check_codes("R4 follows shifts");
      check("R9 pulse count", err_pulses - pulses0, 3);
      load_b_n = 1'b1; wait_clk(SETTLE);

      // R8 shutdown: flag, no disturbance, loading still works
      wake_n = 1'b0; wait_clk(SETTLE);
      check("R8 pd asserted", power_down, 1);
      check_codes("R8 no disturb");
      send_frame(16'h0ABC, 12);
      strobe(1'b0, 1'b1);
      check_codes("R8 load in shutdown");
      wake_n = 1'b1; wait_clk(SETTLE);
      check("R8 pd released", power_down, 0);
      check_codes("R8 after wake");

      // random mix
      pulses0 = err_pulses;
      for (int it = 0; it < 60; it++) begin
         int op = $urandom_range(0, 3);
         case (op)
            0: send_frame(16'($urandom()), $urandom_range(12, 16));
            1: strobe(1'($urandom()), 1'($urandom()));
            2: pulse_clear(1'($urandom()));
            default: begin
               wake_n = ~wake_n; wait_clk(SETTLE);
               check("R8 random pd", power_down, !wake_n);
            end
         endcase
         check_codes("R5 random");
      end
      check("R9 no pulse in legal use", err_pulses - pulses0, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule